// File: doc/BRIEF.md
# Rotating XOR Configuration Checksum

This block computes a 16-bit integrity code over a stream of 16-bit configuration words, one word per clock. A frame opens with a start pulse and closes with a word that carries the last flag. The running value begins at the constant 0xAAAA. Each accepted word is XORed into the running value, and the result is then rotated left by one bit position. A full configuration image is 128 words, but a frame can hold any number of words.

When the final word has been absorbed, the block publishes the code on a result output and pulses a done strobe. If compare mode is enabled on the final beat, the code is also checked against a reference word sampled on that same beat, and a match flag is raised alongside done. The result and the flag hold until the next frame completes.

Top module: `cfgsum_engine`

## Requirements
- R1: After synchronous reset, `sum_o` is 0x0000 and `done_o` and `match_o` are 0.
- R2: A frame's running value starts at 0xAAAA. A one-word frame carrying 0x0000 yields 0x5555, and one carrying 0x0001 yields 0x5557.
- R3: Each word is handled in two steps: first value = value XOR word, then a left rotate by one bit, with bit 15 moving into bit 0 (a word 0x8000 after the seed 0x2AAA wraps to 0x5555).
- R4: Words are combined strictly in arrival order, one XOR-then-rotate step per accepted word. Frames of up to and beyond 128 words give the code that the sequential rule predicts.
- R5: A cycle with `valid_i` low and `start_i` low leaves the running value unchanged, so inserting stall cycles into a frame does not change its result.
- R6: A start pulse reloads the seed. When `valid_i` is high in the same cycle, that word is combined with the seed. A start in the middle of a frame discards the partial value.
- R7: `done_o` is high for exactly the one cycle after the clock edge that absorbs the word flagged last. `sum_o` takes the code in that same cycle and keeps it until another frame completes.
- R8: `match_o` is 1 together with done only when `cmp_en_i` was high on the last beat and the code equals `ref_i` sampled on that beat. Otherwise it is 0. It holds with `sum_o`.
- R9: Words presented with `valid_i` high while no frame is open and `start_i` is low are ignored: no done, and `sum_o` and `match_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a frame and reloads the seed |
| valid_i | input | 1 | Word on `word_i` is present this cycle |
| word_i | input | 16 | Configuration word |
| last_i | input | 1 | Current valid word closes the frame |
| cmp_en_i | input | 1 | Compare the final code with `ref_i` |
| ref_i | input | 16 | Stored reference code, sampled on the last beat |
| sum_o | output | 16 | Completed checksum |
| done_o | output | 1 | One-cycle completion strobe |
| match_o | output | 1 | Code equalled the reference |

## Verification
Two cases let a frame's opening and closing fall in the same cycle: a single-word frame with `start_i`, `valid_i` and `last_i` all high together, and a restart where a new start arrives while a frame is still open. The bench drives both as directed cases. It checks that the one-word result is the seed folded with that word alone, and that after a restart the result reflects only the words that follow the new start. Random frames with stalls mixed in, and with compare mode set and cleared, are judged against a sequential model inside the bench.

// File: rtl/cfgsum_pkg.sv
package cfgsum_pkg;
    localparam int unsigned CW        = 16;
    localparam int unsigned ROT_BITS  = 1;
    localparam int unsigned IMG_WORDS = 128;
    localparam logic [CW-1:0] SEED_VAL = 16'hAAAA;

    typedef logic [CW-1:0] cword_t;

    typedef struct packed {
        logic   open;
        logic   valid;
        logic   last;
        cword_t data;
    } beat_t;

    typedef struct packed {
        logic   fin;
        cword_t value;
    } fold_res_t;
endpackage

// File: rtl/cfgsum_step.sv
module cfgsum_step #(
    parameter int unsigned W   = 16,
    parameter int unsigned ROT = 1
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] next_o
);
    logic [W-1:0] mixed;

    assign mixed = acc_i ^ word_i;

    for (genvar i = 0; i < W; i++) begin : g_rot
        localparam int unsigned SRC = (i + W - ROT) % W;
        assign next_o[i] = mixed[SRC];
    end
endmodule

// File: rtl/cfgsum_accum.sv
module cfgsum_accum
    import cfgsum_pkg::*;
#(
    parameter int unsigned   W    = CW,
    parameter logic [W-1:0]  SEED = SEED_VAL
) (
    input  logic         clk,
    input  logic         rst,
    input  beat_t        beat_i,
    output logic         fin_o,
    output logic [W-1:0] fin_val_o
);
    logic [W-1:0] acc_q;
    logic         busy_q;
    logic         take;
    logic [W-1:0] base;
    logic [W-1:0] folded;

    assign take = beat_i.valid & (beat_i.open | busy_q);
    assign base = beat_i.open ? SEED : acc_q;

    cfgsum_step #(.W(W), .ROT(ROT_BITS)) u_step (
        .acc_i  (base),
        .word_i (beat_i.data),
        .next_o (folded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= SEED;
            busy_q <= 1'b0;
        end else if (take) begin
            acc_q  <= folded;
            busy_q <= ~beat_i.last;
        end else if (beat_i.open) begin
            acc_q  <= SEED;
            busy_q <= 1'b1;
        end
    end

    assign fin_o     = take & beat_i.last;
    assign fin_val_o = folded;

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!beat_i.valid && !beat_i.open) |=> $stable(acc_q)); // R5
    AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !beat_i.open) |=> $stable(acc_q) && !busy_q); // R9
    AST_START_RELOADS: assert property (@(posedge clk) disable iff (rst)
        (beat_i.open && !beat_i.valid) |=> (acc_q == SEED) && busy_q); // R6
endmodule

// File: rtl/cfgsum_result.sv
module cfgsum_result #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fin_i,
    input  logic [W-1:0] val_i,
    input  logic         cmp_en_i,
    input  logic [W-1:0] ref_i,
    output logic [W-1:0] sum_o,
    output logic         done_o,
    output logic         match_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sum_o   <= '0;
            done_o  <= 1'b0;
            match_o <= 1'b0;
        end else begin
            done_o <= fin_i;
            if (fin_i) begin
                sum_o   <= val_i;
                match_o <= cmp_en_i && (val_i == ref_i);
            end
        end
    end

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(fin_i)); // R7
    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(sum_o)); // R7
    AST_MATCH_NEEDS_CMP: assert property (@(posedge clk) disable iff (rst)
        $rose(match_o) |-> $past(cmp_en_i) && done_o); // R8
endmodule

// File: rtl/cfgsum_engine.sv
module cfgsum_engine
    import cfgsum_pkg::*;
#(
    parameter int unsigned  W    = CW,
    parameter logic [W-1:0] SEED = SEED_VAL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         valid_i,
    input  logic [W-1:0] word_i,
    input  logic         last_i,
    input  logic         cmp_en_i,
    input  logic [W-1:0] ref_i,
    output logic [W-1:0] sum_o,
    output logic         done_o,
    output logic         match_o
);
    beat_t        beat;
    logic         fin;
    logic [W-1:0] fin_val;

    assign beat.open  = start_i;
    assign beat.valid = valid_i;
    assign beat.last  = last_i;
    assign beat.data  = word_i;

    cfgsum_accum #(.W(W), .SEED(SEED)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .beat_i    (beat),
        .fin_o     (fin),
        .fin_val_o (fin_val)
    );

    cfgsum_result #(.W(W)) u_result (
        .clk      (clk),
        .rst      (rst),
        .fin_i    (fin),
        .val_i    (fin_val),
        .cmp_en_i (cmp_en_i),
        .ref_i    (ref_i),
        .sum_o    (sum_o),
        .done_o   (done_o),
        .match_o  (match_o)
    );
endmodule

// File: tb/test_cfgsum_engine.sv
module test_cfgsum_engine;
    import cfgsum_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 0, valid_i = 0, last_i = 0, cmp_en_i = 0;
    logic [15:0] word_i = '0, ref_i = '0;
    logic [15:0] sum_o;
    logic        done_o, match_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] fw [0:255];

    always #4 clk = ~clk;

    cfgsum_engine i_cfgsum_engine (
        .clk(clk), .rst(rst), .start_i(start_i), .valid_i(valid_i),
        .word_i(word_i), .last_i(last_i), .cmp_en_i(cmp_en_i), .ref_i(ref_i),
        .sum_o(sum_o), .done_o(done_o), .match_o(match_o)
    );

    function automatic logic [15:0] fold(logic [15:0] a, logic [15:0] w);
        logic [15:0] t;
        t = a ^ w;
        return {t[14:0], t[15]};
    endfunction

    function automatic logic [15:0] model(int n);
        logic [15:0] a;
        a = 16'hAAAA;
        for (int i = 0; i < n; i++) a = fold(a, fw[i]);
        return a;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic beat(logic st, logic v, logic [15:0] w, logic l, logic ce, logic [15:0] r);
        @(negedge clk);
        start_i = st; valid_i = v; word_i = w; last_i = l; cmp_en_i = ce; ref_i = r;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        beat(0, 0, 16'h0, 0, 0, 16'h0);
    endtask

    // sends fw[0..n-1] as a frame; start on first word, optional stalls
    task automatic frame(int n, bit stalls, logic ce, logic [15:0] r);
        for (int i = 0; i < n; i++) begin
            if (stalls && i > 0 && ($urandom % 3 == 0)) begin
                beat(0, 0, 16'($urandom), 0, 0, 16'h0);
                check("R5 no done while stalled", {15'b0, done_o}, 16'h0);
            end
            beat(i == 0, 1, fw[i], i == n - 1, ce, r);
            if (i != n - 1) check("R7 no done mid-frame", {15'b0, done_o}, 16'h0);
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] exp, prev;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        check("R1 sum after reset", sum_o, 16'h0);
        check("R1 done after reset", {15'b0, done_o}, 16'h0);
        check("R1 match after reset", {15'b0, match_o}, 16'h0);

        // R2 one-word frames: start, valid and last together
        beat(1, 1, 16'h0000, 1, 0, 16'h0);
        check("R2 seed fold of 0x0000", sum_o, 16'h5555);
        check("R7 done after last", {15'b0, done_o}, 16'h1);
        idle();
        check("R7 done is one cycle", {15'b0, done_o}, 16'h0);
        check("R7 sum holds", sum_o, 16'h5555);
        beat(1, 1, 16'h0001, 1, 0, 16'h0);
        check("R2 seed fold of 0x0001", sum_o, 16'h5557);

        // R3 wrap: seed ^ 0x8000 ^ ... -> two words so bit15 carries
        fw[0] = 16'h8000; fw[1] = 16'h0000;
        frame(2, 0, 0, 16'h0);
        check("R3 rotate wraps bit15", sum_o, fold(fold(16'hAAAA, 16'h8000), 16'h0));
        fw[0] = 16'h8000 ^ 16'hAAAA ^ 16'h2AAA;
        frame(1, 0, 0, 16'h0);
        check("R3 0x8000 after seed 0x2AAA", sum_o, 16'h5555);

        // R4 order matters
        fw[0] = 16'h1234; fw[1] = 16'hABCD;
        frame(2, 0, 0, 16'h0);
        check("R4 order AB", sum_o, model(2));
        fw[0] = 16'hABCD; fw[1] = 16'h1234;
        frame(2, 0, 0, 16'h0);
        check("R4 order BA", sum_o, model(2));

        // R4 full image
        for (int i = 0; i < IMG_WORDS; i++) fw[i] = 16'(i * 16'h0101 + 16'h0F0F);
        frame(IMG_WORDS, 0, 0, 16'h0);
        check("R4 128-word image", sum_o, model(IMG_WORDS));
        exp = model(IMG_WORDS);
        frame(IMG_WORDS, 1, 0, 16'h0);
        check("R5 stalls do not change image code", sum_o, exp);

        // R6 restart mid-frame
        beat(1, 1, 16'hDEAD, 0, 0, 16'h0);
        beat(0, 1, 16'hBEEF, 0, 0, 16'h0);
        fw[0] = 16'h0F0F; fw[1] = 16'h7777; fw[2] = 16'h1111;
        frame(3, 0, 0, 16'h0);
        check("R6 restart discards partial", sum_o, model(3));
        // start alone then first word without start
        beat(1, 1, 16'h5A5A, 0, 0, 16'h0);
        beat(1, 0, 16'h0, 0, 0, 16'h0);
        beat(0, 1, 16'h3C3C, 1, 0, 16'h0);
        check("R6 start without word reloads seed", sum_o, fold(16'hAAAA, 16'h3C3C));

        // R9 words outside a frame ignored
        prev = sum_o;
        beat(0, 1, 16'h1111, 0, 1, prev);
        beat(0, 1, 16'h2222, 1, 1, prev);
        check("R9 no done outside frame", {15'b0, done_o}, 16'h0);
        check("R9 sum unchanged outside frame", sum_o, prev);
        idle();
        check("R9 match unchanged outside frame", {15'b0, match_o}, 16'h0);

        // R8 compare mode
        fw[0] = 16'hCAFE; fw[1] = 16'hF00D;
        frame(2, 0, 1, model(2));
        check("R8 match on correct ref", {15'b0, match_o}, 16'h1);
        idle();
        check("R8 match holds", {15'b0, match_o}, 16'h1);
        frame(2, 0, 1, model(2) ^ 16'h0100);
        check("R8 no match on wrong ref", {15'b0, match_o}, 16'h0);
        frame(2, 0, 0, model(2));
        check("R8 no match with compare off", {15'b0, match_o}, 16'h0);

        // random frames
        for (int k = 0; k < 24; k++) begin
            int n;
            logic ce, good;
            logic [15:0] r;
            n = 1 + int'($urandom % 140);
            for (int i = 0; i < n; i++) fw[i] = 16'($urandom);
            exp = model(n);
            ce = 1'($urandom);
            good = 1'($urandom);
            r = good ? exp : exp ^ 16'(1 << ($urandom % 16));
            frame(n, 1, ce, r);
            check("R4 random frame code", sum_o, exp);
            check("R7 random frame done", {15'b0, done_o}, 16'h1);
            check("R8 random frame match", {15'b0, match_o}, {15'b0, ce & good});
            if ($urandom % 2 == 0) idle();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule